// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps return addresses for a small processor core. When a subroutine call runs or an interrupt redirects execution, the core strobes a push and presents the full program-counter value. When any of the three return-type instructions runs, the core strobes a pop and takes the saved address in the same cycle. The pointer is internal and software cannot reach it. The stack lies outside both program and data memory.

The storage is a ring of eight 13-bit entries. It raises no overflow or underflow flag. A push beyond eight entries overwrites the oldest entry. A pop on an empty stack wraps round and returns whatever entry the pointer reaches. A push and a pop in the same cycle act as a pop followed by a push: the top entry is returned and then replaced, and the depth stays the same. Decoding of instructions and the program counter itself belong to the core.

Top module: `ret_stack`

## Requirements
- R1: Synchronous active-low reset sets the internal pointer to slot 0 and does not clear the stored entries. A pop in the first cycle after reset therefore returns the entry held in slot 7.
- R2: Pops return pushed addresses in reverse order of pushing (last in, first out).
- R3: Every push stores all 13 bits of `push_pc_i` unchanged, including values with only bit 12 set and the all-ones value.
- R4: The popped address is on `pop_pc_o` combinationally in the same cycle that `pop_i` is high. A push takes effect at the rising edge that ends its cycle.
- R5: Storage is a ring of 8 slots. Push n (counting from 1 after reset) writes slot (n-1) mod 8, so the ninth push overwrites the first and the tenth overwrites the second. No status output exists.
- R6: The pointer also wraps downward. A pop with the pointer at slot 0 returns slot 7, and the next pop returns slot 6.
- R7: With `push_i` and `pop_i` both high, `pop_pc_o` returns the current top, the top slot is replaced with `push_pc_i`, and the depth does not change.
- R8: Cycles with both strobes low leave the pointer and all stored entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Store `push_pc_i` on the stack this cycle |
| push_pc_i | input | 13 | Return address to save |
| pop_i | input | 1 | Remove the top entry this cycle |
| pop_pc_o | output | 13 | Entry just below the pointer; the popped address while `pop_i` is high |

## Verification
A popped address is due in the same cycle as its `pop_i` strobe, with no register on the path. A push is visible at the first pop in any later cycle. The driver changes the strobes at the falling edge and enqueues the result the reference ring predicts for that cycle. The monitor samples `pop_pc_o` 2 ns later, in the middle of the low clock phase, and compares it with the head of the queue, so every comparison falls inside the strobe's own cycle and never on a rising edge. At the end the queue must be empty, which shows that every predicted pop was observed.

// File: rtl/rstk_pkg.sv
// Package rstk_pkg
// Holds the operation encoding shared by the return-stack modules.
// Assumes the two strobes are the only source of stack operations.
package rstk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

    // Map the push/pop strobe pair to an operation
    function automatic stk_op_e decode_op(input logic push, input logic pop);
        stk_op_e op;
        case ({push, pop})
            2'b01:   op = OP_POP;
            2'b10:   op = OP_PUSH;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
// Module rstk_ptr
// Keeps the hidden stack pointer, which wraps modulo DEPTH in both directions.
// It gives the slot to write and the slot that a pop reads.
// Assumes DEPTH >= 2. The pointer always names the next free slot.
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dn;
    logic [PTR_W-1:0] ptr_up;

    // Neighbour slots of the pointer, with explicit wrap
    always_comb begin
        ptr_dn = (ptr_q == '0)   ? LAST : ptr_q - 1'b1;
        ptr_up = (ptr_q == LAST) ? '0   : ptr_q + 1'b1;
    end

    // Pop reads below the pointer; a combined op writes the slot it pops
    always_comb begin
        rd_idx = ptr_dn;
        wr_idx = (op == OP_SWAP) ? ptr_dn : ptr_q;
    end

    // Pointer register: up on push, down on pop, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            case (op)
                OP_PUSH: ptr_q <= ptr_up;
                OP_POP:  ptr_q <= ptr_dn;
                default: ptr_q <= ptr_q;
            endcase
        end
    end

endmodule

// File: rtl/rstk_store.sv
// Module rstk_store
// DEPTH x WIDTH register file with one write port and one asynchronous read port.
// Entries have no reset. A read in the cycle of a write to the same slot
// returns the old contents.
module rstk_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Load this slot when it is the write target
        always_ff @(posedge clk) begin
            if (we && (wr_idx == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    // Asynchronous read of the addressed slot
    always_comb begin
        rd_data = slot_q[rd_idx];
    end

endmodule

// File: rtl/ret_stack.sv
// Module ret_stack
// Circular return-address stack: push on a call or interrupt, pop on a return.
// There are no overflow or underflow flags and the pointer is not visible.
// Assumes the core drives the strobes for one cycle per operation.
module ret_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 13,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_pc_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] pop_pc_o
);

    stk_op_e          op;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             wr_en;

    // Classify this cycle's strobes
    always_comb begin
        op    = decode_op(push_i, pop_i);
        wr_en = (op == OP_PUSH) || (op == OP_SWAP);
    end

    rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    rstk_store #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) u_store (
        .clk     (clk),
        .we      (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_pc_i),
        .rd_idx  (rd_idx),
        .rd_data (pop_pc_o)
    );

endmodule

// File: rtl/rstk_checker.sv
// Module rstk_checker
// Port-level temporal properties of ret_stack, attached with bind.
// A saturating counter of cycles since reset guards every $past depth.
module rstk_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] push_pc_i,
    input logic [ADDR_W-1:0] pop_pc_o
);

    logic [1:0] since_rst;

    // Count clean cycles after reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R4: a lone pop right after a lone push returns that pushed address
    a_r4_pop_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && pop_i && !push_i && $past(push_i && !pop_i))
        |-> (pop_pc_o == $past(push_pc_i)));

    // R7: after a combined push/pop, the next pop returns the replacement value
    a_r7_swap_replaces_top: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && pop_i && !push_i && $past(push_i && pop_i))
        |-> (pop_pc_o == $past(push_pc_i)));

    // R8: an idle cycle between a push and a pop loses nothing
    a_r8_idle_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && pop_i && !push_i && $past(!push_i && !pop_i)
         && $past(push_i && !pop_i, 2))
        |-> (pop_pc_o == $past(push_pc_i, 2)));

    // R2: two pushes then two pops, the second pop returns the first push
    a_r2_lifo_order: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pop_i && !push_i && $past(pop_i && !push_i)
         && $past(push_i && !pop_i, 2) && $past(push_i && !pop_i, 3))
        |-> (pop_pc_o == $past(push_pc_i, 3)));

endmodule

bind ret_stack rstk_checker #(.ADDR_W(ADDR_W)) u_rstk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .push_pc_i (push_pc_i),
    .pop_pc_o  (pop_pc_o)
);

// File: tb/test_ret_stack.sv
// Scoreboard bench for ret_stack. The driver predicts every pop from a
// reference ring and queues it. The monitor compares pop_pc_o mid-cycle.
module test_ret_stack;

    localparam int DEPTH = 8;
    localparam int AW    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [AW-1:0] push_pc_i = '0;
    logic [AW-1:0] pop_pc_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference ring, built from the requirements
    logic [AW-1:0] ref_mem [DEPTH];
    bit            ref_known [DEPTH];
    int            ref_ptr = 0;

    logic [AW-1:0] exp_q [$];
    string         tag_q [$];
    bit            skip_q [$];
    string         cur_req = "R1";

    ret_stack i_ret_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .push_pc_i (push_pc_i),
        .pop_i     (pop_i),
        .pop_pc_o  (pop_pc_o)
    );

    always #4 clk = ~clk;

    // Driver: one stack operation per cycle, changed at the falling edge
    task automatic do_op(input bit psh, input bit pp, input logic [AW-1:0] val);
        int below;
        @(negedge clk);
        push_i    = psh;
        pop_i     = pp;
        push_pc_i = val;
        below = (ref_ptr + DEPTH - 1) % DEPTH;
        if (pp) begin
            exp_q.push_back(ref_mem[below]);
            tag_q.push_back(cur_req);
            skip_q.push_back(!ref_known[below]);
        end
        if (psh && pp) begin
            ref_mem[below] = val;
            ref_known[below] = 1'b1;
        end else if (psh) begin
            ref_mem[ref_ptr] = val;
            ref_known[ref_ptr] = 1'b1;
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end else if (pp) begin
            ref_ptr = below;
        end
    endtask

    task automatic push(input logic [AW-1:0] v);  do_op(1'b1, 1'b0, v);  endtask
    task automatic pop();                         do_op(1'b0, 1'b1, '0); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_op(1'b0, 1'b0, '0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        ref_ptr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each pop 2 ns after the falling edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n && pop_i && !finished) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL %s: unexpected pop, actual=%h expected=<none>", cur_req, pop_pc_o);
            end else begin
                logic [AW-1:0] e;
                string t;
                bit s;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                s = skip_q.pop_front();
                if (!s) begin
                    checks++;
                    if (pop_pc_o !== e) begin
                        failures++;
                        $display("FAIL %s: pop_pc_o actual=%h expected=%h", t, pop_pc_o, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: run did not end, actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            ref_known[i] = 1'b0;
        end
        apply_reset();

        // R2: reverse order of pops
        cur_req = "R2";
        push(13'h0123); push(13'h0456); push(13'h0789);
        pop(); pop(); pop();

        // R3: full-width values
        cur_req = "R3";
        push(13'h1FFF); push(13'h1000); push(13'h0001);
        pop(); pop(); pop();

        // R4: push followed at once by pop, data due in the pop cycle
        cur_req = "R4";
        push(13'h0C3A); pop();

        // R8: idle cycles keep the stack intact
        cur_req = "R8";
        push(13'h0AAA); push(13'h1555); idle(3); pop(); idle(2); pop();

        // R7: combined push and pop replaces the top
        cur_req = "R7";
        push(13'h0111); push(13'h0222);
        do_op(1'b1, 1'b1, 13'h0333);
        pop(); pop();

        // R5: ten pushes wrap the ring; nine pops wrap back round
        cur_req = "R5";
        for (int i = 1; i <= 10; i++) push(AW'(13'h0A00 + i));
        for (int i = 0; i < 9; i++) pop();

        // R6: pops on an empty stack wrap downward
        cur_req = "R6";
        apply_reset();
        for (int i = 0; i < DEPTH; i++) push(AW'(13'h1100 + i));
        for (int i = 0; i < DEPTH; i++) pop();
        pop(); pop();

        // R1: reset sets the pointer to slot 0, entries kept, first pop reads slot 7
        cur_req = "R1";
        apply_reset();
        for (int i = 0; i < DEPTH; i++) push(AW'(13'h0700 + i));
        push(13'h1E01); push(13'h1E02); push(13'h1E03);
        apply_reset();
        pop(); pop();
        push(13'h0042); pop();

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: pending results actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule